// File: doc/BRIEF.md
# Timing Channel Source Selector

This block produces one output of a multi-channel timing and sync generator. A host writes a byte-wide configuration register over a simple register bus. The register picks the channel's source: a value bit held in the register, an external bit input, or one bit of a pattern-memory word shared by all channels. A second bit in the register, or an external enable line, lets the chosen source through to the output.

The output is combinational in the configuration and the inputs, so it follows the pattern word in the same cycle. One read-only bit in the register records the output level as it stood on the clock edge of the most recent write. Software uses it to sample a live timing line without extra hardware. The channel's position among its siblings is a parameter, and it fixes which lane and bit of the pattern word the channel taps.

Top module: `tsg_channel`

## Requirements
- R1: After reset the configuration register reads 0x00 and `chan_out` is low.
- R2: A write with `wr_en` high stores `wr_data[4:0]` on the rising edge. `rd_data[4:0]` shows the stored value from then on and holds it until the next write. The fields are: bit 0 selects the register value, bit 1 selects `ext_bit`, bit 2 selects the pattern bit, bit 3 is the output enable, and bit 4 is the register value.
- R3: With only bit 0 selected and the output enabled, `chan_out` equals bit 4.
- R4: With only bit 1 selected and the output enabled, `chan_out` equals `ext_bit`.
- R5: With only bit 2 selected and the output enabled, `chan_out` equals bit `CHAN_IDX % LANE_W` of lane `CHAN_IDX / LANE_W` of `pat_word`. For 8-bit lanes, lane k is `pat_word[8k+7:8k]`. No other bit of `pat_word` has any effect.
- R6: With none of bits 0 to 2 set, `chan_out` is low whatever the other bits and inputs are.
- R7: With several of bits 0 to 2 set, the source value is the OR of all the selected sources.
- R8: The source value reaches `chan_out` only while configuration bit 3 or `ext_en` is high. Otherwise `chan_out` is low.
- R9: Bit 5 is read-only. On each write it takes the value `chan_out` had just before that edge, and `wr_data[5]` is ignored.
- R10: Bits 6 and 7 always read zero, and the values written to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | CFG_W (8) | Configuration write data |
| rd_data | output | CFG_W (8) | Configuration read-back, including the snapshot bit |
| pat_word | input | NUM_CHAN (32) | Pattern-memory word, one bit per channel |
| ext_bit | input | 1 | External data bit for this channel |
| ext_en | input | 1 | External output enable for this channel |
| chan_out | output | 1 | Channel timing output |

## Verification
The bench sweeps all 32 settings of the five writable bits against all eight combinations of external bit, external enable and pattern bit. In the pattern word, every bit other than the tapped one is driven to the opposite value, so a design that taps the wrong lane or bit fails at once. Each write sets the unused bits and the snapshot bit in the data, so a design that stores them shows non-zero upper bits or a wrong snapshot. Because every write's snapshot is compared with the output level before that write, a design that samples the output after the new configuration takes effect is caught whenever the output changes. Settings with several sources selected catch a design that uses priority instead of OR. The enable cases catch a design that uses AND for the two enables, or that ignores the external line.

// File: rtl/tsgc_pkg.sv
package tsgc_pkg;
   localparam int CFG_W       = 8;
   localparam int POS_SEL_REG = 0;
   localparam int POS_SEL_EXT = 1;
   localparam int POS_SEL_PAT = 2;
   localparam int POS_OUT_EN  = 3;
   localparam int POS_REG_VAL = 4;
   localparam int POS_SNAP    = 5;
   localparam logic [CFG_W-1:0] WR_MASK = 8'h1F;
endpackage

// File: rtl/tsgc_pat_tap.sv
module tsgc_pat_tap #(
   parameter int NUM_CHAN = 32,
   parameter int LANE_W   = 8,
   parameter int CHAN_IDX = 0
) (
   input  logic [NUM_CHAN-1:0] pat_word,
   output logic                pat_bit
);
   localparam int NUM_LANES = NUM_CHAN / LANE_W;
   localparam int TAP_LANE  = CHAN_IDX / LANE_W;
   localparam int TAP_BIT   = CHAN_IDX % LANE_W;

   if (NUM_CHAN % LANE_W != 0) begin : g_bad_lane
      $error("NUM_CHAN must be a multiple of LANE_W");
   end
   if (CHAN_IDX < 0 || CHAN_IDX >= NUM_CHAN) begin : g_bad_idx
      $error("CHAN_IDX out of range");
   end

   logic [NUM_LANES-1:0] lane_hit;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      localparam logic [LANE_W-1:0] LANE_MASK =
         (l == TAP_LANE) ? (LANE_W'(1) << TAP_BIT) : '0;
      assign lane_hit[l] = |(pat_word[l*LANE_W +: LANE_W] & LANE_MASK);
   end

   assign pat_bit = |lane_hit;
endmodule

// File: rtl/tsgc_cfg_reg.sv
module tsgc_cfg_reg
   import tsgc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   input  logic             live_out,
   output logic [CFG_W-1:0] cfg_q
);
   logic [CFG_W-1:0] snap_field;
   assign snap_field = {{(CFG_W-1){1'b0}}, live_out} << POS_SNAP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en) begin
         cfg_q <= (wr_data & WR_MASK) | snap_field;
      end
   end
endmodule

// File: rtl/tsgc_src_gate.sv
module tsgc_src_gate (
   input  logic sel_reg,
   input  logic sel_ext,
   input  logic sel_pat,
   input  logic reg_val,
   input  logic out_en,
   input  logic ext_bit,
   input  logic ext_en,
   input  logic pat_bit,
   output logic chan_out
);
   logic src_val;
   logic gate_open;

   always_comb begin
      src_val   = (sel_reg & reg_val) | (sel_ext & ext_bit) | (sel_pat & pat_bit);
      gate_open = out_en | ext_en;
      chan_out  = src_val & gate_open;
   end
endmodule

// File: rtl/tsg_channel.sv
module tsg_channel
   import tsgc_pkg::*;
#(
   parameter int NUM_CHAN = 32,
   parameter int LANE_W   = 8,
   parameter int CHAN_IDX = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CFG_W-1:0]    wr_data,
   output logic [CFG_W-1:0]    rd_data,
   input  logic [NUM_CHAN-1:0] pat_word,
   input  logic                ext_bit,
   input  logic                ext_en,
   output logic                chan_out
);
   logic [CFG_W-1:0] cfg_q;
   logic             pat_bit;
   logic             out_w;

   tsgc_pat_tap #(
      .NUM_CHAN(NUM_CHAN),
      .LANE_W  (LANE_W),
      .CHAN_IDX(CHAN_IDX)
   ) u_tap (
      .pat_word(pat_word),
      .pat_bit (pat_bit)
   );

   tsgc_cfg_reg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .live_out(out_w),
      .cfg_q   (cfg_q)
   );

   tsgc_src_gate u_gate (
      .sel_reg (cfg_q[POS_SEL_REG]),
      .sel_ext (cfg_q[POS_SEL_EXT]),
      .sel_pat (cfg_q[POS_SEL_PAT]),
      .reg_val (cfg_q[POS_REG_VAL]),
      .out_en  (cfg_q[POS_OUT_EN]),
      .ext_bit (ext_bit),
      .ext_en  (ext_en),
      .pat_bit (pat_bit),
      .chan_out(out_w)
   );

   assign chan_out = out_w;
   assign rd_data  = cfg_q;
endmodule

// File: rtl/tsgc_chk.sv
module tsgc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       ext_en,
   input logic [7:0] rd_data,
   input logic       chan_out
);
   a_r6_nosel_low: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[2:0] == 3'b000) |-> !chan_out);

   a_r8_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data[3] && !ext_en) |-> !chan_out);

   a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[5] == $past(chan_out)));

   a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7:6] == 2'b00);

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rd_data));
endmodule

bind tsg_channel tsgc_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .ext_en  (ext_en),
   .rd_data (rd_data),
   .chan_out(chan_out)
);

// File: tb/test_tsg_channel.sv
module test_tsg_channel;
   localparam int NCH = 32;
   localparam int IDX = 13;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [7:0]     wr_data = '0;
   logic [7:0]     rd_data;
   logic [NCH-1:0] pat_word = '0;
   logic           ext_bit = 1'b0;
   logic           ext_en = 1'b0;
   logic           chan_out;

   int checks = 0;
   int errors = 0;
   logic [4:0] cur_cfg = '0;
   logic       cur_pb = 1'b0;

   always #5 clk = ~clk;

   tsg_channel #(.NUM_CHAN(NCH), .LANE_W(8), .CHAN_IDX(IDX)) i_tsg_channel (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pat_word(pat_word), .ext_bit(ext_bit),
      .ext_en(ext_en), .chan_out(chan_out)
   );

   function automatic logic model(logic [4:0] c, logic eb, logic ee, logic pb);
      return ((c[0] & c[4]) | (c[1] & eb) | (c[2] & pb)) & (c[3] | ee);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_inputs(logic eb, logic ee, logic pb);
      ext_bit  = eb;
      ext_en   = ee;
      cur_pb   = pb;
      pat_word = pb ? (NCH'(1) << IDX) : ~(NCH'(1) << IDX);
   endtask

   task automatic write_cfg(logic [4:0] c);
      logic exp_snap;
      exp_snap = model(cur_cfg, ext_bit, ext_en, cur_pb);
      wr_en   = 1'b1;
      wr_data = {2'b11, ~exp_snap, c};
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
      cur_cfg = c;
      #1;
      check("R2", 32'(rd_data[4:0]), 32'(c));
      check("R9", 32'(rd_data[5]), 32'(exp_snap));
      check("R10", 32'(rd_data[7:6]), 32'd0);
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 32'(rd_data), 32'd0);
      check("R1", 32'(chan_out), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R1", 32'(rd_data), 32'd0);

      for (int c = 0; c < 32; c++) begin
         write_cfg(5'(c));
         for (int v = 0; v < 8; v++) begin
            string tag;
            logic [4:0] cc;
            cc = 5'(c);
            set_inputs(v[0], v[1], v[2]);
            #1;
            if (cc[2:0] == 3'b000)                tag = "R6";
            else if (!cc[3] && !v[1])             tag = "R8";
            else if ($countones(cc[2:0]) > 1)     tag = "R7";
            else if (cc[0])                       tag = "R3";
            else if (cc[1])                       tag = "R4";
            else                                  tag = "R5";
            check(tag, 32'(chan_out), 32'(model(cc, v[0], v[1], v[2])));
            @(negedge clk);
            check("R2", 32'(rd_data[4:0]), 32'(cc));
         end
      end

      // Snapshot: output high before write, then low.
      set_inputs(1'b0, 1'b0, 1'b0);
      write_cfg(5'h19);
      #1 check("R3", 32'(chan_out), 32'd1);
      write_cfg(5'h00);
      check("R9", 32'(rd_data[5]), 32'd1);
      write_cfg(5'h00);
      check("R9", 32'(rd_data[5]), 32'd0);

      // Pattern tap: walk one bit; only the tapped position drives the output.
      write_cfg(5'h0C);
      for (int b = 0; b < NCH; b++) begin
         pat_word = NCH'(1) << b;
         #1;
         check("R5", 32'(chan_out), (b == IDX) ? 32'd1 : 32'd0);
         @(negedge clk);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule